// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM with 18-bit words split into two 9-bit byte lanes. Write data is posted: it is sampled two enabled clock edges after the write command, which is the same delay as the read pipeline. Because of this, reads and writes can follow each other in any order at one command per clock, and the shared data bus never needs an idle cycle.

All control inputs are registered on the rising edge. These are the address, the read/write select, three chip selects, the byte write enables, the burst advance and the burst order. A global clock enable freezes the whole pipeline. An output enable gates the output drive. Because the model has no real tri-state drive, a data-valid flag takes its place. A read that targets a word whose write data has not yet reached the array still returns the newest data. That pending data is merged with the array contents lane by lane. The array is written so that block RAM can be inferred. Its depth is set by a parameter.

Top module: `ntd_sram`

## Requirements
- R1: A write command (`rd_nwr`=0, all selects high, `adv`=0) takes its address and byte enables on the edge where it is issued. It takes the `wdata` on the second enabled edge after that and stores it in the array.
- R2: A read command (`rd_nwr`=1) updates `rdata` and sets `rvalid` on the second enabled edge after it is issued, provided `oe_n` is low at that edge.
- R3: Any mix of reads and writes runs at one command per enabled cycle. A read returns the data of every write issued before it, including writes whose data is still in the pipeline.
- R4: The command slot of a write never drives the output. After the edge where that write's data is taken, `rvalid` is 0.
- R5: Active-low `bwe_n[0]` enables bits 8:0 and `bwe_n[1]` enables bits 17:9. A lane whose enable is high keeps its old contents.
- R6: With `adv`=0, if any of `sel_a`, `sel_b`, `sel_c` is low, the cycle issues a no-op. Two enabled edges later `rvalid` is 0. Commands issued earlier still complete.
- R7: While `cke_n`=1, no state changes. This covers the pipeline, the burst counter, the array, `rdata` and `rvalid`. The `wdata` present on that edge is ignored.
- R8: If `oe_n` is high at the edge where read data would appear, `rvalid` is 0 after that edge. The array is not affected.
- R9: When `adv`=1, the previous operation continues and `addr`, the selects and `rd_nwr` are ignored. For the k-th advance, the low two address bits become base+k mod 4 if `burst_lin` was 1 when the burst started, and base XOR k if it was 0. The upper bits stay as they were. Byte enables are sampled on every beat. A burst that follows a no-op stays a no-op.
- R10: Reset (synchronous, active high) clears `rvalid` and sets every pipeline stage and the burst state to no-op, so no write reaches the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low; high stalls everything |
| sel_a | input | 1 | Chip select A, active high |
| sel_b | input | 1 | Chip select B, active high |
| sel_c | input | 1 | Chip select C, active high |
| adv | input | 1 | Burst advance: continue the previous operation |
| burst_lin | input | 1 | Burst order at start: 1 linear, 0 interleaved |
| rd_nwr | input | 1 | 1 read, 0 write |
| addr | input | ADDR_W | Word address |
| bwe_n | input | LANES | Byte lane write enables, active low |
| wdata | input | LANES*LANE_W | Write data, taken two enabled edges after its command |
| oe_n | input | 1 | Output enable, active low |
| rdata | output | LANES*LANE_W | Registered read data |
| rvalid | output | 1 | Output drive flag in place of tri-state |

## Verification
In a single cycle, the block can take write data for an earlier command into the array while it also reads the array for a later command to the same word. The array read then returns the old contents, and the bypass has to supply the new bytes in each enabled lane. The bench provokes this by confining addresses to a few words and mixing reads, writes, partial byte enables, bursts and stalls at random. A bench-side model applies each write on the edge its data is taken and predicts each read from that model. Every output slot is compared with the prediction.

// File: rtl/ntd_pkg.sv
package ntd_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;

  // low two address bits of the k-th beat of a four-beat wrapping burst
  function automatic logic [1:0] beat_lo(input logic [1:0] base,
                                         input logic [1:0] k,
                                         input logic       linear);
    return linear ? (base + k) : (base ^ k);
  endfunction

endpackage

// File: rtl/ntd_burst_seq.sv
module ntd_burst_seq
  import ntd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              adv,
  input  logic              sel_all,
  input  logic              rd_nwr,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be,
  output op_e               iss_op,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [LANES-1:0]  iss_be
);

  op_e               st_op;
  logic [ADDR_W-1:0] st_base;
  logic [1:0]        st_cnt;
  logic              st_lin;
  logic [1:0]        nxt_cnt;

  assign nxt_cnt = st_cnt + 2'd1;
  assign iss_be  = be;

  always_comb begin
    if (!adv) begin
      iss_op   = sel_all ? (rd_nwr ? OP_RD : OP_WR) : OP_NOP;
      iss_addr = addr;
    end else begin
      iss_op   = st_op;
      iss_addr = st_base;
      iss_addr[1:0] = beat_lo(st_base[1:0], nxt_cnt, st_lin);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_op   <= OP_NOP;
      st_base <= '0;
      st_cnt  <= '0;
      st_lin  <= 1'b0;
    end else if (en) begin
      if (!adv) begin
        st_op   <= iss_op;
        st_base <= addr;
        st_cnt  <= '0;
        st_lin  <= linear;
      end else begin
        st_cnt  <= nxt_cnt;
      end
    end
  end

endmodule

// File: rtl/ntd_byte_ram.sv
module ntd_byte_ram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic                    we,
  input  logic [LANES-1:0]        be,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (en) begin
        if (we && be[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        q <= mem[raddr];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/ntd_sram.sv
module ntd_sram
  import ntd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cke_n,
  input  logic                    sel_a,
  input  logic                    sel_b,
  input  logic                    sel_c,
  input  logic                    adv,
  input  logic                    burst_lin,
  input  logic                    rd_nwr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        bwe_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);

  localparam int DATA_W = LANES * LANE_W;

  logic              en;
  logic              sel_all;
  op_e               iss_op;
  logic [ADDR_W-1:0] iss_addr;
  logic [LANES-1:0]  iss_be;

  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_be, s2_be;

  logic [LANES-1:0]  byp_mask;
  logic [DATA_W-1:0] byp_data;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] merged;
  logic              ram_we;

  assign en      = ~cke_n;
  assign sel_all = sel_a & sel_b & sel_c;

  ntd_burst_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .adv      (adv),
    .sel_all  (sel_all),
    .rd_nwr   (rd_nwr),
    .linear   (burst_lin),
    .addr     (addr),
    .be       (~bwe_n),
    .iss_op   (iss_op),
    .iss_addr (iss_addr),
    .iss_be   (iss_be)
  );

  // data of the write in stage two is taken on this edge
  assign ram_we = en && !rst && (s2_op == OP_WR);

  ntd_byte_ram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
    .clk   (clk),
    .en    (en),
    .we    (ram_we),
    .be    (s2_be),
    .waddr (s2_addr),
    .wdata (wdata),
    .raddr (s1_addr),
    .rdata (ram_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = byp_mask[g] ? byp_data[g*LANE_W +: LANE_W]
                                                    : ram_q[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op    <= OP_NOP;
      s2_op    <= OP_NOP;
      s1_addr  <= '0;
      s2_addr  <= '0;
      s1_be    <= '0;
      s2_be    <= '0;
      byp_mask <= '0;
      byp_data <= '0;
      rvalid   <= 1'b0;
      rdata    <= '0;
    end else if (en) begin
      s1_op    <= iss_op;
      s1_addr  <= iss_addr;
      s1_be    <= iss_be;
      s2_op    <= s1_op;
      s2_addr  <= s1_addr;
      s2_be    <= s1_be;
      // array read for stage one misses the write landing on this same edge
      byp_mask <= (s2_op == OP_WR && s2_addr == s1_addr) ? s2_be : '0;
      byp_data <= wdata;
      rvalid   <= (s2_op == OP_RD) && !oe_n;
      if (s2_op == OP_RD) rdata <= merged;
    end
  end

endmodule

// File: rtl/ntd_sram_chk.sv
module ntd_sram_chk
  import ntd_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              cke_n,
  input logic              oe_n,
  input logic              rvalid,
  input logic [DATA_W-1:0] rdata,
  input op_e               s2_op
);

  p_reset_idle_r10: assert property (@(posedge clk) rst |=> !rvalid);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    cke_n |=> ($stable(rdata) && $stable(rvalid)));

  p_oe_blank_r8: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && oe_n) |=> !rvalid);

  p_write_slot_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && s2_op == OP_WR) |=> !rvalid);

  p_noop_slot_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && s2_op == OP_NOP) |=> !rvalid);

  p_read_drives_r2: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !oe_n && s2_op == OP_RD) |=> rvalid);

endmodule

bind ntd_sram ntd_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cke_n  (cke_n),
  .oe_n   (oe_n),
  .rvalid (rvalid),
  .rdata  (rdata),
  .s2_op  (s2_op)
);

// File: tb/tb_ntd_sram.sv
`timescale 1ns/1ps
module tb_ntd_sram;

  localparam int AW    = 6;
  localparam int NL    = 2;
  localparam int LW    = 9;
  localparam int DW    = NL * LW;
  localparam int DEPTH = 1 << AW;
  localparam int NOP = 0, RD = 1, WR = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          d_cke_n, d_sa, d_sb, d_sc, d_adv, d_lin, d_rdnwr, d_oe_n;
  logic [AW-1:0] d_addr;
  logic [NL-1:0] d_bwe_n;
  logic [DW-1:0] d_wdata;
  logic [DW-1:0] rdata;
  logic          rvalid;

  always #2 clk = ~clk;

  ntd_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
    .clk(clk), .rst(rst), .cke_n(d_cke_n), .sel_a(d_sa), .sel_b(d_sb), .sel_c(d_sc),
    .adv(d_adv), .burst_lin(d_lin), .rd_nwr(d_rdnwr), .addr(d_addr), .bwe_n(d_bwe_n),
    .wdata(d_wdata), .oe_n(d_oe_n), .rdata(rdata), .rvalid(rvalid)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [DW-1:0] mm [DEPTH];
  int            m1_op, m2_op, b_op;
  logic [AW-1:0] m1_a, m2_a, b_base;
  logic [NL-1:0] m1_be, m2_be;
  logic [1:0]    b_cnt;
  logic          b_lin;
  logic          exp_v;
  logic [DW-1:0] exp_d;

  function automatic logic [1:0] blo(input logic [1:0] b, input logic [1:0] k, input logic lin);
    return lin ? 2'(b + k) : (b ^ k);
  endfunction

  task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  endtask

  // one clock: model the edge from the driven inputs, then compare outputs
  task automatic step(input string tag);
    int            iop;
    logic [AW-1:0] ia;
    d_wdata = DW'($urandom);
    if (!d_cke_n) begin
      exp_v = (m2_op == RD) && !d_oe_n;
      if (m2_op == RD) exp_d = mm[m2_a];
      if (m2_op == WR)
        for (int l = 0; l < NL; l++)
          if (m2_be[l]) mm[m2_a][l*LW +: LW] = d_wdata[l*LW +: LW];
      if (!d_adv) begin
        iop    = (d_sa && d_sb && d_sc) ? (d_rdnwr ? RD : WR) : NOP;
        ia     = d_addr;
        b_op   = iop; b_base = d_addr; b_cnt = 2'd0; b_lin = d_lin;
      end else begin
        b_cnt  = b_cnt + 2'd1;
        iop    = b_op;
        ia     = b_base;
        ia[1:0] = blo(b_base[1:0], b_cnt, b_lin);
      end
      m2_op = m1_op; m2_a = m1_a; m2_be = m1_be;
      m1_op = iop;   m1_a = ia;   m1_be = ~d_bwe_n;
    end
    @(posedge clk);
    #1;
    check(tag, rvalid === exp_v, 32'(rvalid), 32'(exp_v));
    if (exp_v) check(tag, rdata === exp_d, 32'(rdata), 32'(exp_d));
  endtask

  task automatic cmd(input bit rd, input logic [AW-1:0] a, input logic [NL-1:0] bn);
    d_adv = 0; d_sa = 1; d_sb = 1; d_sc = 1; d_rdnwr = rd; d_addr = a; d_bwe_n = bn;
  endtask

  task automatic idle();
    d_adv = 0; d_sa = 0; d_sb = 1; d_sc = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h1d5eed));
    rst = 1; d_cke_n = 0; d_oe_n = 0; d_lin = 1; d_wdata = '0;
    cmd(0, '0, '0);
    m1_op = NOP; m2_op = NOP; b_op = NOP; m1_a = '0; m2_a = '0; m1_be = '0; m2_be = '0;
    b_base = '0; b_cnt = '0; b_lin = 0; exp_v = 0; exp_d = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R10", rvalid === 1'b0, 32'(rvalid), 0);
    rst = 0;
    idle();
    step("R10"); step("R10");

    // fill every word with full writes, then read back-to-back
    for (int a = 0; a < DEPTH; a++) begin cmd(0, AW'(a), '0); step("R1"); end
    for (int a = 0; a < DEPTH; a++) begin cmd(1, AW'(a), '0); step("R2"); end
    idle(); step("R2"); step("R2");

    // strict alternation write/read on one word
    for (int i = 0; i < 40; i++) begin cmd(i[0], 6'd7, '0); step("R4"); end

    // partial lanes, read right behind the write (pending data merge)
    cmd(0, 6'd5, 2'b10); step("R5");
    cmd(1, 6'd5, 2'b11); step("R5");
    cmd(0, 6'd5, 2'b01); step("R5");
    cmd(1, 6'd5, 2'b11); step("R5");
    idle(); step("R5"); step("R5");

    // tight-address mix for forwarding
    for (int i = 0; i < 300; i++) begin
      cmd($urandom_range(0, 1), AW'($urandom_range(0, 3)), NL'($urandom)); step("R3");
    end

    // deselect by one select low at a time
    for (int i = 0; i < 60; i++) begin
      cmd($urandom_range(0, 1), AW'($urandom), NL'($urandom));
      case ($urandom_range(0, 3))
        0: d_sa = 0;
        1: d_sb = 0;
        2: d_sc = 0;
        default: ;
      endcase
      step("R6");
    end

    // stalls
    for (int i = 0; i < 200; i++) begin
      cmd($urandom_range(0, 1), AW'($urandom_range(0, 3)), NL'($urandom));
      d_cke_n = ($urandom_range(0, 2) == 0);
      step("R7");
    end
    d_cke_n = 0;

    // output enable
    for (int i = 0; i < 100; i++) begin
      cmd($urandom_range(0, 1), AW'($urandom_range(0, 7)), NL'($urandom));
      d_oe_n = $urandom_range(0, 1);
      step("R8");
    end
    d_oe_n = 0;

    // bursts, both orders, garbage on ignored pins
    for (int b = 0; b < 40; b++) begin
      cmd($urandom_range(0, 1), AW'($urandom), NL'($urandom));
      d_lin = $urandom_range(0, 1);
      if (b % 5 == 4) d_sb = 0;
      step("R9");
      for (int k = 0; k < 3; k++) begin
        d_adv = 1; d_addr = AW'($urandom); d_rdnwr = $urandom_range(0, 1);
        d_sa = $urandom_range(0, 1); d_bwe_n = NL'($urandom);
        step("R9");
      end
    end

    // everything mixed
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) d_adv = 1;
      else cmd($urandom_range(0, 1), AW'($urandom_range(0, 7)), NL'($urandom));
      d_addr = ($urandom_range(0, 3) == 0) ? AW'($urandom) : d_addr;
      d_sc = ($urandom_range(0, 9) != 0);
      d_lin = $urandom_range(0, 1);
      d_cke_n = ($urandom_range(0, 7) == 0);
      d_oe_n = ($urandom_range(0, 9) == 0);
      step("R3");
    end
    summary();
  end

endmodule